// File: doc/BRIEF.md
# Timer Channel Status Flag Register

This block holds the 8-bit status word of one channel of a 16-bit up/down timer. It watches the counter value, the counting direction and four single-cycle compare/capture event pulses, and it keeps a sticky flag for each event. It also keeps a flag for each counter wrap, in either direction. A processor reads the word and writes it through a plain strobe interface: a read strobe, a write strobe, 8-bit write data and an always-valid 8-bit read value.

A flag can only be cleared deliberately. Software must first read the word while the flag shows 1, which arms that flag. Its next write must then carry a 0 in that bit position. Any write consumes all armed bits, whatever data it carries. A parameter picks the channel variant:
- a phase-counting channel, with a live direction bit and an underflow flag;
- a plain channel, with a direction bit and bit 5 reserved at 0;
- a minimal channel, with bit 7 reserved at 1 and bit 5 reserved at 0.

Top module: `tmr_stat_reg`

## Requirements
- R1: While reset is asserted, and after release until the first clock edge, rd_data equals 8'hC0.
- R2: Bit 6 of rd_data always reads 1, and writes to it have no effect.
- R3: For the phase and plain variants, bit 7 shows cnt_up as sampled at the previous clock edge (1 = counting up, 0 = counting down). For the minimal variant, bit 7 always reads 1. Writes never change bit 7.
- R4: A pulse on evt_i[k] (k = 0..3, event A at bit 0 through event D at bit 3) sets rd_data[k] from the next cycle on. The flag then stays set until it is cleared.
- R5: Bit 4 (overflow) sets in the cycle after cnt_val moves from 16'hFFFF to 16'h0000 between two consecutive clock edges.
- R6: Bit 5 (underflow) sets in the cycle after cnt_val moves from 16'h0000 to 16'hFFFF, but only on the phase variant and only while phase_mode is 1. On the plain and minimal variants, bit 5 always reads 0.
- R7: A cycle with rd_stb high arms every flag (bits 5..0) that reads 1 in that cycle.
- R8: A write with wr_stb high clears an armed flag whose wr_data bit is 0. A 1 in that bit leaves the flag set, and a 0 written to an unarmed flag has no effect.
- R9: Every write disarms all flags, whatever the data. If rd_stb and wr_stb are high in the same cycle, the write uses the earlier arming and the read arms afresh.
- R10: If a set event and a valid clearing write meet in the same cycle, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | 16 | Current timer counter value |
| cnt_up | input | 1 | Counting direction, 1 = up |
| phase_mode | input | 1 | Channel is running in phase-counting mode |
| evt_i | input | 4 | Compare/capture event pulses, A at bit 0 |
| rd_stb | input | 1 | Register read strobe |
| wr_stb | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Current status word |

## Verification
The assertions check on every cycle that the reserved bits hold their constants and that the direction bit follows the sampled direction. They also check that event and wrap conditions raise their flags on the next cycle even when a clearing write competes, that no event flag rises without a pulse, and that no flag falls except under a write carrying 0 in that position. Whether a fall was earned by a prior read that saw a 1, and whether a write disarms everything, only the bench's scenarios can show. These include a write without a read, a write of 1 followed by a write of 0, a read and a write in the same cycle, and underflow with phase mode off, all compared against a reference model across the three channel variants.

// File: rtl/tmr_stat_pkg.sv
package tmr_stat_pkg;

    typedef enum logic [1:0] {
        CHAN_PHASE = 2'd0,
        CHAN_PLAIN = 2'd1,
        CHAN_MIN   = 2'd2
    } chan_kind_e;

    localparam int REG_W   = 8;
    localparam int EVT_N   = 4;
    localparam int BIT_OVF = EVT_N;
    localparam int BIT_UDF = EVT_N + 1;
    localparam int BIT_RSV = EVT_N + 2;
    localparam int BIT_DIR = EVT_N + 3;
    localparam int FLAG_N  = EVT_N + 2;

    function automatic bit kind_has_dir(chan_kind_e k);
        return k != CHAN_MIN;
    endfunction

    function automatic bit kind_has_udf(chan_kind_e k);
        return k == CHAN_PHASE;
    endfunction

endpackage

// File: rtl/tmr_stat_wrap_det.sv
module tmr_stat_wrap_det #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             ovf_o,
    output logic             udf_o
);

    typedef struct packed {
        logic [CNT_W-1:0] prev;
        logic             valid;
    } wrap_st_t;

    wrap_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.prev  = cnt_i;
        st_d.valid = 1'b1;
        ovf_o = st_q.valid && (st_q.prev == {CNT_W{1'b1}}) && (cnt_i == '0);
        udf_o = st_q.valid && (st_q.prev == '0) && (cnt_i == {CNT_W{1'b1}});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tmr_stat_dir.sv
module tmr_stat_dir #(
    parameter bit HAS_DIR = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic up_i,
    output logic dir_bit_o
);

    typedef struct packed {
        logic dir;
    } dir_st_t;

    dir_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.dir = up_i;
        dir_bit_o = HAS_DIR ? st_q.dir : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.dir <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tmr_stat_flag_bit.sv
module tmr_stat_flag_bit #(
    parameter bit PRESENT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wr_bit_i,
    output logic flag_o
);

    typedef struct packed {
        logic flag;
        logic armed;
    } flag_st_t;

    flag_st_t st_d, st_q;
    logic     set_eff;
    logic     clr_ok;

    always_comb begin
        st_d    = st_q;
        set_eff = PRESENT && set_i;
        // a clear needs the arming left by an earlier read and a 0 in this bit
        clr_ok  = wr_i && st_q.armed && !wr_bit_i;
        if (clr_ok) begin
            st_d.flag = 1'b0;
        end
        if (set_eff) begin
            st_d.flag = 1'b1;
        end
        if (rd_i) begin
            st_d.armed = st_q.flag;
        end else if (wr_i) begin
            st_d.armed = 1'b0;
        end
        flag_o = st_q.flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tmr_stat_reg.sv
module tmr_stat_reg
    import tmr_stat_pkg::*;
#(
    parameter chan_kind_e KIND  = CHAN_PHASE,
    parameter int         CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_up,
    input  logic             phase_mode,
    input  logic [EVT_N-1:0] evt_i,
    input  logic             rd_stb,
    input  logic             wr_stb,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data
);

    localparam bit HAS_DIR = kind_has_dir(KIND);
    localparam bit HAS_UDF = kind_has_udf(KIND);

    logic [FLAG_N-1:0] set_vec;
    logic [FLAG_N-1:0] flag_vec;
    logic              ovf_hit;
    logic              udf_hit;
    logic              dir_bit;
    logic              unused_wr_hi;

    assign unused_wr_hi = ^wr_data[REG_W-1:FLAG_N];

    tmr_stat_wrap_det #(.CNT_W(CNT_W)) u_wrap (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt_i (cnt_val),
        .ovf_o (ovf_hit),
        .udf_o (udf_hit)
    );

    tmr_stat_dir #(.HAS_DIR(HAS_DIR)) u_dir (
        .clk       (clk),
        .rst_n     (rst_n),
        .up_i      (cnt_up),
        .dir_bit_o (dir_bit)
    );

    always_comb begin
        set_vec              = '0;
        set_vec[EVT_N-1:0]   = evt_i;
        set_vec[BIT_OVF]     = ovf_hit;
        set_vec[BIT_UDF]     = udf_hit && phase_mode;
    end

    for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
        localparam bit PRES = (i != BIT_UDF) || HAS_UDF;
        tmr_stat_flag_bit #(.PRESENT(PRES)) u_flag (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (set_vec[i]),
            .rd_i     (rd_stb),
            .wr_i     (wr_stb),
            .wr_bit_i (wr_data[i]),
            .flag_o   (flag_vec[i])
        );
    end

    always_comb begin
        rd_data               = '0;
        rd_data[FLAG_N-1:0]   = flag_vec;
        rd_data[BIT_RSV]      = 1'b1;
        rd_data[BIT_DIR]      = dir_bit;
    end

endmodule

// File: rtl/tmr_stat_chk.sv
module tmr_stat_chk
    import tmr_stat_pkg::*;
#(
    parameter chan_kind_e KIND  = CHAN_PHASE,
    parameter int         CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt_val,
    input logic             cnt_up,
    input logic [EVT_N-1:0] evt_i,
    input logic             wr_stb,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data
);

    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    AST_RSV_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[BIT_RSV]); // R2

    if (kind_has_dir(KIND)) begin : g_dir
        AST_DIR_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
            seen_q |-> (rd_data[BIT_DIR] == $past(cnt_up))); // R3
    end else begin : g_nodir
        AST_DIR_RSV_ONE: assert property (@(posedge clk) disable iff (!rst_n)
            rd_data[BIT_DIR]); // R3
    end

    if (!kind_has_udf(KIND)) begin : g_noudf
        AST_UDF_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_data[BIT_UDF]); // R6
    end

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((rd_data[EVT_N-1:0] & $past(evt_i)) == $past(evt_i))); // R4

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && (evt_i != '0)) |=> ((rd_data[EVT_N-1:0] & $past(evt_i)) == $past(evt_i))); // R10

    AST_OVF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && ($past(cnt_val) == {CNT_W{1'b1}}) && (cnt_val == '0)) |=> rd_data[BIT_OVF]); // R5

    AST_NO_SPURIOUS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> ((rd_data[EVT_N-1:0] & ~$past(rd_data[EVT_N-1:0]) & ~$past(evt_i)) == '0)); // R4

    AST_FALL_NEEDS_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (($past(rd_data[FLAG_N-1:0]) & ~rd_data[FLAG_N-1:0]
                     & ~({FLAG_N{$past(wr_stb)}} & ~$past(wr_data[FLAG_N-1:0]))) == '0)); // R8

endmodule

bind tmr_stat_reg tmr_stat_chk #(.KIND(KIND), .CNT_W(CNT_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_val (cnt_val),
    .cnt_up  (cnt_up),
    .evt_i   (evt_i),
    .wr_stb  (wr_stb),
    .wr_data (wr_data),
    .rd_data (rd_data)
);

// File: tb/tmr_stat_reg_tb.sv
module tmr_stat_reg_tb_top;
    import tmr_stat_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cnt_val;
    logic        cnt_up;
    logic        phase_mode;
    logic [3:0]  evt_i;
    logic        rd_stb;
    logic        wr_stb;
    logic [7:0]  wr_data;
    logic [7:0]  rd_phase, rd_plain, rd_min;

    int checks = 0;
    int fails  = 0;

    logic [5:0]  m_flag, m_arm;
    logic [15:0] m_prev;
    logic        m_valid, m_dir;

    always #5 clk = ~clk;

    tmr_stat_reg #(.KIND(CHAN_PHASE)) dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_up(cnt_up),
        .phase_mode(phase_mode), .evt_i(evt_i), .rd_stb(rd_stb),
        .wr_stb(wr_stb), .wr_data(wr_data), .rd_data(rd_phase));

    tmr_stat_reg #(.KIND(CHAN_PLAIN)) dut_plain_i (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_up(cnt_up),
        .phase_mode(phase_mode), .evt_i(evt_i), .rd_stb(rd_stb),
        .wr_stb(wr_stb), .wr_data(wr_data), .rd_data(rd_plain));

    tmr_stat_reg #(.KIND(CHAN_MIN)) dut_min_i (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_up(cnt_up),
        .phase_mode(phase_mode), .evt_i(evt_i), .rd_stb(rd_stb),
        .wr_stb(wr_stb), .wr_data(wr_data), .rd_data(rd_min));

    function automatic logic [7:0] exp_view(chan_kind_e k);
        logic [7:0] v;
        v      = 8'h40;                                   // R2 bit 6
        v[7]   = (k == CHAN_MIN) ? 1'b1 : m_dir;           // R3
        v[5]   = (k == CHAN_PHASE) ? m_flag[5] : 1'b0;     // R6
        v[4:0] = m_flag[4:0];                             // R4 R5
        return v;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " phase"}, rd_phase, exp_view(CHAN_PHASE));
        chk({tag, " plain"}, rd_plain, exp_view(CHAN_PLAIN));
        chk({tag, " min"},   rd_min,   exp_view(CHAN_MIN));
    endtask

    // drive one cycle of inputs, advance the model, land on the next falling edge
    task automatic step(input logic [15:0] cv, input logic up, input logic pm,
                        input logic [3:0] ev, input logic rd, input logic wr,
                        input logic [7:0] wd);
        logic ovf, udf;
        logic [5:0] set_v, clr_v, arm_n;
        cnt_val = cv; cnt_up = up; phase_mode = pm; evt_i = ev;
        rd_stb = rd; wr_stb = wr; wr_data = wd;
        ovf   = m_valid && (m_prev == 16'hFFFF) && (cv == 16'h0000);
        udf   = m_valid && (m_prev == 16'h0000) && (cv == 16'hFFFF) && pm;
        set_v = {udf, ovf, ev};
        clr_v = wr ? (m_arm & ~wd[5:0]) : 6'h00;
        arm_n = rd ? m_flag : (wr ? 6'h00 : m_arm);
        m_flag  = (m_flag & ~clr_v) | set_v;
        m_arm   = arm_n;
        m_prev  = cv;
        m_valid = 1'b1;
        m_dir   = up;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5EED));
        rst_n = 1'b0; cnt_val = 16'h0; cnt_up = 1'b0; phase_mode = 1'b0;
        evt_i = 4'h0; rd_stb = 1'b0; wr_stb = 1'b0; wr_data = 8'h00;
        m_flag = '0; m_arm = '0; m_prev = '0; m_valid = 1'b0; m_dir = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 reset phase", rd_phase, 8'hC0);
        chk("R1 reset plain", rd_plain, 8'hC0);
        chk("R1 reset min",   rd_min,   8'hC0);
        rst_n = 1'b1;
        #1;
        chk("R1 after release", rd_phase, 8'hC0);
        @(negedge clk);
        m_valid = 1'b0; m_dir = 1'b1;

        // R4 event A sets
        step(16'h0000, 1'b1, 1'b0, 4'h1, 1'b0, 1'b0, 8'h00);
        chk("R4 event A", rd_phase, 8'hC1); check_all("R4");
        // R8 zero written without a prior read
        step(16'h0000, 1'b1, 1'b0, 4'h0, 1'b0, 1'b1, 8'h00);
        chk("R8 unarmed zero", rd_phase, 8'hC1);
        // R7 read arms
        step(16'h0000, 1'b1, 1'b0, 4'h0, 1'b1, 1'b0, 8'h00);
        check_all("R7");
        // R8 writing one leaves flag, R9 write disarms
        step(16'h0000, 1'b1, 1'b0, 4'h0, 1'b0, 1'b1, 8'hFF);
        chk("R8 write one", rd_phase, 8'hC1);
        step(16'h0000, 1'b1, 1'b0, 4'h0, 1'b0, 1'b1, 8'h00);
        chk("R9 arm consumed", rd_phase, 8'hC1);
        // R8 proper clear; R2 and R3 writes to bits 7,6 ignored
        step(16'h0000, 1'b1, 1'b0, 4'h0, 1'b1, 1'b0, 8'h00);
        step(16'h0000, 1'b1, 1'b0, 4'h0, 1'b0, 1'b1, 8'h3E);
        chk("R8 clear A", rd_phase, 8'hC0); check_all("R2 R3 R8");
        // R10 set beats clear
        step(16'h0000, 1'b1, 1'b0, 4'h2, 1'b0, 1'b0, 8'h00);
        step(16'h0000, 1'b1, 1'b0, 4'h0, 1'b1, 1'b0, 8'h00);
        step(16'h0000, 1'b1, 1'b0, 4'h2, 1'b0, 1'b1, 8'h00);
        chk("R10 set wins", rd_phase, 8'hC2);
        // R9 read and write in one cycle: write sees no arming, read arms
        step(16'h0000, 1'b1, 1'b0, 4'h0, 1'b1, 1'b1, 8'h00);
        chk("R9 same-cycle rw", rd_phase, 8'hC2);
        step(16'h0000, 1'b1, 1'b0, 4'h0, 1'b0, 1'b1, 8'h00);
        chk("R9 rearmed clear", rd_phase, 8'hC0);
        // R6 underflow with phase mode off does not set
        step(16'hFFFF, 1'b1, 1'b0, 4'h0, 1'b0, 1'b0, 8'h00);
        chk("R6 phase off", rd_phase, 8'hC0);
        // R5 overflow
        step(16'h0000, 1'b1, 1'b0, 4'h0, 1'b0, 1'b0, 8'h00);
        chk("R5 overflow", rd_phase, 8'hD0); check_all("R5");
        // R6 underflow with phase mode on
        step(16'hFFFF, 1'b1, 1'b1, 4'h0, 1'b0, 1'b0, 8'h00);
        chk("R6 underflow phase", rd_phase, 8'hF0);
        chk("R6 underflow plain", rd_plain, 8'hD0);
        chk("R6 underflow min",   rd_min,   8'hD0);
        // R3 counting down
        step(16'h1234, 1'b0, 1'b1, 4'h0, 1'b0, 1'b0, 8'h00);
        chk("R3 down phase", rd_phase, 8'h70);
        chk("R3 down plain", rd_plain, 8'h50);
        chk("R3 down min",   rd_min,   8'hD0);

        // random traffic, wrap values biased in
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] cv;
            logic [7:0]  wd;
            int sel;
            sel = int'($urandom % 8);
            cv  = (sel == 0) ? 16'h0000 : (sel == 1) ? 16'hFFFF : 16'($urandom);
            wd  = 8'($urandom);
            step(cv, 1'($urandom), 1'($urandom),
                 {($urandom % 10 == 0), ($urandom % 10 == 0),
                  ($urandom % 10 == 0), ($urandom % 10 == 0)},
                 ($urandom % 3 == 0), ($urandom % 3 == 0), wd);
            check_all("R3 R4 R5 R6 R7 R8 R9 R10 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule